// File: doc/BRIEF.md
# Complementary PWM Output Stage with Break

This block turns one internal reference waveform into a complementary output pair, a true lane and an inverted lane. Each lane has its own drive-enable pin, so a pin released to high impedance shows up as drive enable 0 with the level pin at 0. When both lanes are enabled, a programmable dead-time delays each lane's switch to its active level. This means the two lanes are never active together while they change over.

A main output enable gates the whole pair. A write strobe sets or clears it. A break input clears it in the same cycle, and a write cannot set it again while break is high. Two off-state selects decide what a lane does when it is not passing the reference. The run select applies while the main enable is set. The idle select applies while it is clear. Each lane can float, or it can be driven at a fixed level.

On a break with the idle select set, the outputs go to their polarity levels at once. After the dead-time they move to the programmed idle levels. The block has no data stream, so every pin is a plain level or strobe.

Top module: `pwm_comp_out`

## Requirements
- R1: After reset the main enable is 0 and both lanes are undriven (level 0, drive enable 0).
- R2: A write strobe with data 1 sets the main enable after the next clock edge, and with data 0 clears it. A high break input forces the main enable output to 0 in the same cycle. A high break input also blocks a set write, so the enable stays 0 after break falls until a new write.
- R3: Polarity bit 0 means active high: a lane's pin level is its internal active state XOR its polarity bit. With the main enable set and both lanes enabled, the true lane is active while the registered reference is 1, and the inverted lane is active while it is 0. Each lane reaches the active state only after the dead-time count of clock edges following the edge that captures the reference change; both lanes are inactive in between.
- R4: With the main enable set and both lanes enabled, the two lanes are never active at the same time.
- R5: With the main enable set and both lane enables clear, both lanes are undriven.
- R6: With the main enable set, the run select 0 and exactly one lane enabled, the enabled lane follows the reference (XOR polarity) one edge after it changes, with no dead-time, and the other lane is undriven.
- R7: With the main enable set, the run select 1 and exactly one lane enabled, the disabled lane is driven at its polarity bit (its inactive level).
- R8: With the main enable clear and either the idle select 0 or no lane enabled, both lanes are undriven, whatever the run select is.
- R9: With the main enable clear, the idle select 1 and at least one lane enabled, both lanes are driven. They show their polarity bits from the cycle in which the main enable drops. They show their idle-level bits after dead-time plus one clock edges, counting the first edge at which the enable is low.
- R10: A lane's idle bit asks for the active state when it differs from that lane's polarity bit. If both idle bits ask for the active state, the inverted lane is held at its polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ocref_i | input | 1 | Reference waveform |
| brk_i | input | 1 | Break request, level sensitive |
| mainen_wr_i | input | 1 | Write strobe for the main enable |
| mainen_wdata_i | input | 1 | Value written to the main enable |
| run_off_sel_i | input | 1 | Off-state select while the main enable is set |
| idle_off_sel_i | input | 1 | Off-state select while the main enable is clear |
| oc_en_i | input | 1 | True-lane enable |
| ocn_en_i | input | 1 | Inverted-lane enable |
| oc_pol_i | input | 1 | True-lane polarity (1 = active low) |
| ocn_pol_i | input | 1 | Inverted-lane polarity (1 = active low) |
| oc_idle_i | input | 1 | True-lane idle level |
| ocn_idle_i | input | 1 | Inverted-lane idle level |
| dead_time_i | input | DT_W | Dead-time in clock cycles |
| main_en_o | output | 1 | Effective main enable |
| oc_o | output | 1 | True-lane level |
| oc_drv_o | output | 1 | True-lane drive enable |
| ocn_o | output | 1 | Inverted-lane level |
| ocn_drv_o | output | 1 | Inverted-lane drive enable |

## Verification
The reference is registered once, so a reference change reaches a lane one edge later, and a further dead-time count of edges later when dead-time applies. Break acts on the main enable output and on the polarity levels within the same cycle. The switch to idle levels comes dead-time plus one edges after that. The bench drives inputs at falling edges and samples one nanosecond after rising edges. It counts edges from each stimulus so that every check lands on the exact edge at which the result is due. For the table sweep it waits three edges with zero dead-time so that every result has settled.

// File: rtl/pwm_comp_pkg.sv
package pwm_comp_pkg;
  localparam int LANES = 2;
  localparam int LANE_T = 0;
  localparam int LANE_N = 1;

  typedef struct packed {
    logic lvl;
    logic drv;
  } lane_out_t;
endpackage

// File: rtl/pwm_dt_gen.sv
module pwm_dt_gen #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            ref_q_o,
  output logic            pos_act_o,
  output logic            neg_act_o
);
  logic            ref_q;
  logic [DT_W-1:0] cnt_q;
  logic            settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      cnt_q <= '0;
    end else if (ref_i != ref_q) begin
      ref_q <= ref_i;
      cnt_q <= dead_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign settled   = (cnt_q == '0);
  assign ref_q_o   = ref_q;
  assign pos_act_o = ref_q & settled;
  assign neg_act_o = ~ref_q & settled;

  // R3: an edge that captures a new reference value starts a gap when dead-time is nonzero
  p_dead_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ref_q != $past(ref_q)) && ($past(dead_i) != '0)) |-> (!pos_act_o && !neg_act_o));
endmodule

// File: rtl/pwm_brk_ctrl.sv
module pwm_brk_ctrl #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            brk_i,
  input  logic            wr_i,
  input  logic            wdata_i,
  input  logic            idle_sel_i,
  input  logic            any_en_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            main_en_o,
  output logic            idle_done_o
);
  logic            main_q;
  logic            done_q;
  logic [DT_W-1:0] icnt_q;
  logic            idle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      main_q <= 1'b0;
    else if (brk_i)  main_q <= 1'b0;
    else if (wr_i)   main_q <= wdata_i;
  end

  assign main_en_o = main_q & ~brk_i;
  assign idle_run  = ~main_en_o & idle_sel_i & any_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q <= '0;
      done_q <= 1'b0;
    end else if (!idle_run) begin
      icnt_q <= dead_i;
      done_q <= 1'b0;
    end else if (icnt_q == '0) begin
      done_q <= 1'b1;
    end else begin
      icnt_q <= icnt_q - 1'b1;
    end
  end

  assign idle_done_o = done_q;

  // R2: a set write issued during break has no effect
  p_set_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i && wr_i && wdata_i) |=> !main_q);
  // R9: the idle levels never appear while the enable is still set
  p_idle_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    main_en_o |=> !done_q);
endmodule

// File: rtl/pwm_out_lane.sv
module pwm_out_lane
  import pwm_comp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      main_en_i,
  input  logic      run_sel_i,
  input  logic      idle_sel_i,
  input  logic      own_en_i,
  input  logic      peer_en_i,
  input  logic      pol_i,
  input  logic      idle_lvl_i,
  input  logic      act_dt_i,
  input  logic      act_raw_i,
  input  logic      idle_done_i,
  output lane_out_t out_o
);
  always_comb begin
    out_o = '{lvl: 1'b0, drv: 1'b0};
    if (main_en_i) begin
      if (own_en_i && peer_en_i)       out_o = '{lvl: act_dt_i ^ pol_i, drv: 1'b1};
      else if (own_en_i)               out_o = '{lvl: act_raw_i ^ pol_i, drv: 1'b1};
      else if (peer_en_i && run_sel_i) out_o = '{lvl: pol_i, drv: 1'b1};
    end else if (idle_sel_i && (own_en_i || peer_en_i)) begin
      out_o = '{lvl: idle_done_i ? idle_lvl_i : pol_i, drv: 1'b1};
    end
  end

  // R8: with the enable clear and no idle drive, the lane floats
  p_idle_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_en_i && !idle_sel_i) |-> (!out_o.drv && !out_o.lvl));
  // R9: while waiting for the idle levels, the lane sits at its polarity bit
  p_brk_pol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_en_i && idle_sel_i && (own_en_i || peer_en_i) && !idle_done_i)
      |-> (out_o.drv && (out_o.lvl == pol_i)));
endmodule

// File: rtl/pwm_comp_out.sv
module pwm_comp_out
  import pwm_comp_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ocref_i,
  input  logic            brk_i,
  input  logic            mainen_wr_i,
  input  logic            mainen_wdata_i,
  input  logic            run_off_sel_i,
  input  logic            idle_off_sel_i,
  input  logic            oc_en_i,
  input  logic            ocn_en_i,
  input  logic            oc_pol_i,
  input  logic            ocn_pol_i,
  input  logic            oc_idle_i,
  input  logic            ocn_idle_i,
  input  logic [DT_W-1:0] dead_time_i,
  output logic            main_en_o,
  output logic            oc_o,
  output logic            oc_drv_o,
  output logic            ocn_o,
  output logic            ocn_drv_o
);
  logic             ref_q, pos_act, neg_act, idle_done, main_en;
  logic [LANES-1:0] en_v, pol_v, idle_v, act_dt_v, act_raw_v;
  logic             both_idle_active;
  lane_out_t        lane_out [LANES];

  pwm_dt_gen #(.DT_W(DT_W)) u_dt (
    .clk(clk), .rst_n(rst_n), .ref_i(ocref_i), .dead_i(dead_time_i),
    .ref_q_o(ref_q), .pos_act_o(pos_act), .neg_act_o(neg_act)
  );

  pwm_brk_ctrl #(.DT_W(DT_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .brk_i(brk_i), .wr_i(mainen_wr_i),
    .wdata_i(mainen_wdata_i), .idle_sel_i(idle_off_sel_i),
    .any_en_i(oc_en_i | ocn_en_i), .dead_i(dead_time_i),
    .main_en_o(main_en), .idle_done_o(idle_done)
  );

  assign both_idle_active = (oc_idle_i != oc_pol_i) && (ocn_idle_i != ocn_pol_i);

  assign en_v[LANE_T]      = oc_en_i;
  assign en_v[LANE_N]      = ocn_en_i;
  assign pol_v[LANE_T]     = oc_pol_i;
  assign pol_v[LANE_N]     = ocn_pol_i;
  assign idle_v[LANE_T]    = oc_idle_i;
  assign idle_v[LANE_N]    = both_idle_active ? ocn_pol_i : ocn_idle_i;
  assign act_dt_v[LANE_T]  = pos_act;
  assign act_dt_v[LANE_N]  = neg_act;
  assign act_raw_v[LANE_T] = ref_q;
  assign act_raw_v[LANE_N] = ~ref_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pwm_out_lane u_lane (
      .clk(clk), .rst_n(rst_n), .main_en_i(main_en),
      .run_sel_i(run_off_sel_i), .idle_sel_i(idle_off_sel_i),
      .own_en_i(en_v[g]), .peer_en_i(en_v[LANES-1-g]),
      .pol_i(pol_v[g]), .idle_lvl_i(idle_v[g]),
      .act_dt_i(act_dt_v[g]), .act_raw_i(act_raw_v[g]),
      .idle_done_i(idle_done), .out_o(lane_out[g])
    );
  end

  assign main_en_o = main_en;
  assign oc_o      = lane_out[LANE_T].lvl;
  assign oc_drv_o  = lane_out[LANE_T].drv;
  assign ocn_o     = lane_out[LANE_N].lvl;
  assign ocn_drv_o = lane_out[LANE_N].drv;

  // R4: complementary lanes are never active together
  p_no_dual_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (main_en_o && oc_en_i && ocn_en_i) |-> !((oc_o ^ oc_pol_i) && (ocn_o ^ ocn_pol_i)));
  // R5: enable set, both lanes off -> both float
  p_both_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_en_o && !oc_en_i && !ocn_en_i) |-> (!oc_drv_o && !ocn_drv_o && !oc_o && !ocn_o));
  // R10: idle drive never puts both lanes active
  p_idle_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_en_o && idle_off_sel_i) |-> !((oc_o ^ oc_pol_i) && (ocn_o ^ ocn_pol_i)));
  // R2: break holds the enable low
  p_brk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> (brk_i ? !main_en_o : 1'b1));
endmodule

// File: tb/pwm_comp_out_tb_top.sv
module pwm_comp_out_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ocref = 0, brk = 0, wr = 0, wdata = 0, rsel = 0, isel = 0;
  logic ce = 0, cne = 0, pol = 0, poln = 0, idl = 0, idln = 0;
  logic [7:0] dt = '0;
  logic me_o, oc, ocd, ocn, ocnd;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_comp_out #(.DT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ocref_i(ocref), .brk_i(brk),
    .mainen_wr_i(wr), .mainen_wdata_i(wdata), .run_off_sel_i(rsel),
    .idle_off_sel_i(isel), .oc_en_i(ce), .ocn_en_i(cne),
    .oc_pol_i(pol), .ocn_pol_i(poln), .oc_idle_i(idl), .ocn_idle_i(idln),
    .dead_time_i(dt), .main_en_o(me_o), .oc_o(oc), .oc_drv_o(ocd),
    .ocn_o(ocn), .ocn_drv_o(ocnd)
  );

  // [13]me [12]run_sel [11]idle_sel [10]ce [9]cne [8]pol [7]poln [6]idl [5]idln [4]ref
  // [3]oc [2]oc_drv [1]ocn [0]ocn_drv
  localparam logic [13:0] VEC [15] = '{
    14'b1_0_0_1_1_0_0_0_0_1_1_1_0_1,
    14'b1_0_0_1_1_0_0_0_0_0_0_1_1_1,
    14'b1_0_0_1_1_1_1_0_0_1_0_1_1_1,
    14'b1_1_0_0_0_0_0_0_0_1_0_0_0_0,
    14'b1_0_0_1_0_0_0_0_0_1_1_1_0_0,
    14'b1_0_0_0_1_0_0_0_0_0_0_0_1_1,
    14'b1_1_0_1_0_0_1_0_0_1_1_1_1_1,
    14'b1_1_0_0_1_1_0_0_0_0_1_1_1_1,
    14'b0_0_0_1_1_0_0_0_0_1_0_0_0_0,
    14'b0_0_1_0_0_0_0_1_1_1_0_0_0_0,
    14'b0_0_1_1_0_0_0_1_0_1_1_1_0_1,
    14'b0_0_1_1_1_0_0_1_1_0_1_1_0_1,
    14'b0_0_1_0_1_1_0_0_1_0_0_1_0_1,
    14'b0_0_1_1_1_0_0_0_1_0_0_1_1_1,
    14'b0_1_0_1_0_0_0_0_0_1_0_0_0_0
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic edge_s();
    @(posedge clk); #1;
  endtask

  task automatic chk4(input string req, input logic e_oc, input logic e_ocd,
                      input logic e_ocn, input logic e_ocnd);
    chk(req, "oc", oc, e_oc);
    chk(req, "oc_drv", ocd, e_ocd);
    chk(req, "ocn", ocn, e_ocn);
    chk(req, "ocn_drv", ocnd, e_ocnd);
  endtask

  function automatic string tag_of(input logic [13:0] v);
    if (v[13]) begin
      if (v[10] && v[9])        return "R3";
      if (!v[10] && !v[9])      return "R5";
      return v[12] ? "R7" : "R6";
    end
    if (!(v[11] && (v[10] || v[9]))) return "R8";
    if ((v[6] != v[8]) && (v[5] != v[7])) return "R10";
    return "R9";
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #12; rst_n = 1'b1;
    edge_s();
    // R1: reset state
    chk("R1", "main_en", me_o, 1'b0);
    chk4("R1", 0, 0, 0, 0);

    // table sweep, zero dead-time
    for (int i = 0; i < 15; i++) begin
      logic [13:0] v;
      v = VEC[i];
      @(negedge clk);
      rsel = v[12]; isel = v[11]; ce = v[10]; cne = v[9];
      pol = v[8]; poln = v[7]; idl = v[6]; idln = v[5]; ocref = v[4];
      if (v[13]) begin wr = 1; wdata = 1; end else brk = 1;
      @(negedge clk); wr = 0; brk = 0;
      edge_s(); edge_s(); edge_s();
      chk(tag_of(v), "main_en", me_o, v[13]);
      chk4(tag_of(v), v[3], v[2], v[1], v[0]);
    end

    // R3: dead-time gap on both transitions, dead-time = 3
    @(negedge clk);
    rsel = 0; isel = 0; ce = 1; cne = 1; pol = 0; poln = 0; ocref = 0;
    dt = 8'd3; wr = 1; wdata = 1;
    @(negedge clk); wr = 0;
    repeat (5) @(negedge clk);
    ocref = 1;
    for (int k = 0; k < 3; k++) begin
      edge_s(); chk("R3", "oc gap", oc, 1'b0); chk("R3", "ocn gap", ocn, 1'b0);
    end
    edge_s(); chk("R3", "oc after dt", oc, 1'b1); chk("R4", "ocn after dt", ocn, 1'b0);
    @(negedge clk); ocref = 0;
    for (int k = 0; k < 3; k++) begin
      edge_s(); chk("R3", "oc gap2", oc, 1'b0); chk("R3", "ocn gap2", ocn, 1'b0);
    end
    edge_s(); chk("R3", "ocn after dt", ocn, 1'b1); chk("R4", "oc after dt2", oc, 1'b0);

    // R3: zero dead-time, one edge of latency
    @(negedge clk); dt = 0; repeat (3) @(negedge clk);
    ocref = 1;
    edge_s(); chk("R3", "oc dt0", oc, 1'b1); chk("R3", "ocn dt0", ocn, 1'b0);

    // R6: single lane ignores dead-time
    @(negedge clk); dt = 8'd3; cne = 0; ocref = 0;
    repeat (6) @(negedge clk);
    ocref = 1;
    edge_s(); chk("R6", "oc no gap", oc, 1'b1); chk("R6", "ocn float", ocnd, 1'b0);

    // R9: break -> polarity levels at once, idle after dt+1 edges (dt = 2)
    @(negedge clk);
    dt = 8'd2; ce = 1; cne = 1; isel = 1; pol = 0; poln = 1; idl = 1; idln = 1; ocref = 1;
    repeat (6) @(negedge clk);
    brk = 1; #1;
    chk("R2", "main_en in break", me_o, 1'b0);
    chk4("R9", 0, 1, 1, 1);
    edge_s(); chk4("R9", 0, 1, 1, 1);
    edge_s(); chk4("R9", 0, 1, 1, 1);
    edge_s(); chk4("R9", 1, 1, 1, 1);

    // R2: set blocked during break, no auto re-enable
    @(negedge clk); wr = 1; wdata = 1;
    @(negedge clk); wr = 0; brk = 0;
    edge_s(); chk("R2", "no set in break", me_o, 1'b0);
    @(negedge clk); wr = 1; wdata = 1;
    edge_s(); chk("R2", "set after break", me_o, 1'b1);
    @(negedge clk); wdata = 0;
    edge_s(); chk("R2", "clear write", me_o, 1'b0);
    @(negedge clk); wr = 0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule